// File: doc/BRIEF.md
# Supply and Watchdog Reset Combiner

This block merges a set of already-digitized supervision flags into two active-low reset outputs for a system-on-chip. The flags report whether the peripheral supply, the battery-side supply and the internal supply are healthy. They also report overvoltage and undervoltage on the core supply, an overcurrent condition on the core regulator while it switches on, and the state of an external watchdog. A strobe marks each regulator cycle.

Short dips on the battery-side flag are ignored by a glitch filter. The filter length is set in system clock cycles and defaults to 20 µs at 200 MHz. A core-supply fault only acts once it has been present on more than a set number of consecutive regulator-cycle strobes. An overcurrent seen while the regulator is being enabled is latched and stays latched until the regulator is disabled.

The primary reset is released only while every condition is healthy. The secondary reset also needs the watchdog to report correct servicing. Both outputs are registered, and an asynchronous power-on reset input forces them low and clears all filter state.

Top module: `rst_merge`

## Requirements
- R1: While `porN` is low, `rstN` and `rst2N` are 0 at once, without waiting for a clock edge. The battery low counter, the core-fault chain and the overcurrent latch are cleared, so low samples taken before reset count for nothing afterwards.
- R2: `rst2N` is 1 exactly when `rstN` would be 1 and `wdOk` was 1 at the same sampling edge. With `wdOk` = 0 and all else healthy, the outputs read `rstN`=1 and `rst2N`=0.
- R3: `periOk` = 0 sampled at an edge makes both outputs 0 after that edge.
- R4: A low run on `battOk` of at most `GLITCH_CYC` consecutive sampled cycles has no effect. The sample that makes the run `GLITCH_CYC`+1 long drives both outputs to 0 at that edge. The first high sample releases them.
- R5: A strobe on `regTick` with `coreOver` or `coreUnder` set counts as a faulty regulator cycle. A strobe with neither set clears the count. Once more than `CORE_TICKS` (default 4) consecutive faulty strobes have been seen, both outputs go 0 on the second edge after the last one. A clean strobe releases them on the second edge after it.
- R6: `regOvc` is latched only while `regEn` is 1, and is ignored while `regEn` is 0. Once latched, the fault holds both outputs 0 until `regEn` has been 0 at an edge. The outputs go 0 on the second edge after the sampled overcurrent and go 1 again on the second edge after the disabling edge.
- R7: `wdBad` = 1 sampled at an edge makes both outputs 0 after that edge.
- R8: `intOk` = 0 sampled at an edge makes both outputs 0 after that edge.
- R9: The outputs are registered. With no filtered or latched fault pending, they follow the direct flags with one clock of latency, including the first edge after `porN` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| periOk | input | 1 | Peripheral supply above threshold |
| battOk | input | 1 | Battery-side supply above threshold (filtered) |
| intOk | input | 1 | Internal supply above threshold |
| coreOver | input | 1 | Core supply in overvoltage |
| coreUnder | input | 1 | Core supply in undervoltage |
| regTick | input | 1 | One-clock strobe per regulator cycle |
| regEn | input | 1 | Core regulator enable, switch-on in progress |
| regOvc | input | 1 | Core regulator overcurrent |
| wdOk | input | 1 | Watchdog serviced correctly |
| wdBad | input | 1 | Watchdog triggered incorrectly |
| rstN | output | 1 | Primary reset, active low |
| rst2N | output | 1 | Secondary reset, active low, also gated by `wdOk` |

## Verification
The assertions assume that every flag is synchronous to `clk` and that `regTick` is a single-cycle strobe. They also assume that `porN` is released away from a clock edge and that `GLITCH_CYC` is at least one. The stimulus changes all inputs only just after a falling clock edge, and it pulses `regTick` for exactly one cycle with idle cycles between pulses. It also releases `porN` on a falling edge, so the sampled values seen by the design and by the behavioural reference model are always the same.

// File: rtl/rst_merge_pkg.sv
`timescale 1ns/1ps
package rst_merge_pkg;

  // Fault strobes handed from the filtering control to the output datapath.
  typedef struct packed {
    logic battTrip;  // battery-side dip lasted past the glitch window
    logic coreTrip;  // core supply fault persisted over too many regulator cycles
    logic ovcTrip;   // overcurrent latched during regulator switch-on
  } trip_t;

  // Width of a counter that must hold values 0..maxVal (never below 1 bit).
  function automatic int cntWidth(input int maxVal);
    return (maxVal > 0) ? $clog2(maxVal + 1) : 1;
  endfunction

endpackage

// File: rtl/rst_merge_ctrl.sv
`timescale 1ns/1ps
module rst_merge_ctrl
  import rst_merge_pkg::*;
#(
  parameter int GLITCH_CYC = 4000,
  parameter int CORE_TICKS = 4
) (
  input  logic  clk,
  input  logic  porN,
  input  logic  battOk,
  input  logic  coreOver,
  input  logic  coreUnder,
  input  logic  regTick,
  input  logic  regEn,
  input  logic  regOvc,
  output trip_t trips
);

  localparam int CNT_W     = cntWidth(GLITCH_CYC);
  localparam int CHAIN_LEN = CORE_TICKS + 1;

  // ---------------- battery-side glitch filter ----------------
  logic battTrip;

  generate
    if (GLITCH_CYC == 0) begin : g_noFilter
      assign battTrip = !battOk;
    end else begin : g_filter
      logic [CNT_W-1:0] lowCnt;

      // Counts consecutive low samples, saturating at the window length.
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) begin
          lowCnt <= '0;
        end else if (battOk) begin
          lowCnt <= '0;
        end else if (lowCnt != CNT_W'(GLITCH_CYC)) begin
          lowCnt <= lowCnt + 1'b1;
        end
      end

      // Trip on the sample that extends the low run past the window.
      assign battTrip = !battOk && (lowCnt == CNT_W'(GLITCH_CYC));

      // R4: a dip that is one sample long never trips.
      assert_short_dip_R4: assert property (@(posedge clk) disable iff (!porN)
        ($past(battOk) && !battOk) |-> !battTrip);

      // R4: a high sample always empties the counter.
      assert_counter_clear_R4: assert property (@(posedge clk) disable iff (!porN)
        battOk |=> (lowCnt == '0));
    end
  endgenerate

  // ---------------- core-supply persistence chain ----------------
  logic [CHAIN_LEN-1:0] heldChain;
  logic                 coreBad;

  assign coreBad = coreOver || coreUnder;

  generate
    for (genvar s = 0; s < CHAIN_LEN; s++) begin : g_stage
      logic stageIn;
      if (s == 0) begin : g_head
        assign stageIn = 1'b1;
      end else begin : g_body
        assign stageIn = heldChain[s-1];
      end

      always_ff @(posedge clk or negedge porN) begin
        if (!porN) begin
          heldChain[s] <= 1'b0;
        end else if (regTick) begin
          heldChain[s] <= coreBad ? stageIn : 1'b0;
        end
      end
    end
  endgenerate

  // R5: the last stage can only rise on a faulty regulator strobe.
  assert_core_rise_on_tick_R5: assert property (@(posedge clk) disable iff (!porN)
    $rose(heldChain[CHAIN_LEN-1]) |-> $past(regTick && coreBad));

  // R5: a clean regulator strobe empties the chain.
  assert_core_clean_clears_R5: assert property (@(posedge clk) disable iff (!porN)
    (regTick && !coreBad) |=> (heldChain == '0));

  // R5: the chain only changes on a regulator strobe.
  assert_core_stable_R5: assert property (@(posedge clk) disable iff (!porN)
    !regTick |=> $stable(heldChain));

  // ---------------- overcurrent latch ----------------
  logic ovcHeld;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      ovcHeld <= 1'b0;
    end else if (regEn && regOvc) begin
      ovcHeld <= 1'b1;
    end else if (!regEn) begin
      ovcHeld <= 1'b0;
    end
  end

  // R6: latch sets only from an overcurrent seen while enabled.
  assert_ovc_needs_en_R6: assert property (@(posedge clk) disable iff (!porN)
    $rose(ovcHeld) |-> $past(regEn && regOvc));

  // R6: the latch holds as long as the regulator stays enabled.
  assert_ovc_holds_R6: assert property (@(posedge clk) disable iff (!porN)
    (ovcHeld && regEn) |=> ovcHeld);

  assign trips.battTrip = battTrip;
  assign trips.coreTrip = heldChain[CHAIN_LEN-1];
  assign trips.ovcTrip  = ovcHeld;

endmodule

// File: rtl/rst_merge_dp.sv
`timescale 1ns/1ps
module rst_merge_dp
  import rst_merge_pkg::*;
(
  input  logic  clk,
  input  logic  porN,
  input  trip_t trips,
  input  logic  periOk,
  input  logic  intOk,
  input  logic  wdBad,
  input  logic  wdOk,
  output logic  rstN,
  output logic  rst2N
);

  logic primaryOk;
  logic anyTrip;

  assign anyTrip   = trips.battTrip || trips.coreTrip || trips.ovcTrip;
  assign primaryOk = periOk && intOk && !wdBad && !anyTrip;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rstN  <= 1'b0;
      rst2N <= 1'b0;
    end else begin
      rstN  <= primaryOk;
      rst2N <= primaryOk && wdOk;
    end
  end

  // R1: power-on reset holds both outputs low.
  assert_por_low_R1: assert property (@(posedge clk)
    !porN |-> (!rstN && !rst2N));

  // R2: the secondary reset never releases ahead of the primary.
  assert_rst2_within_rst_R2: assert property (@(posedge clk) disable iff (!porN)
    rst2N |-> rstN);

  // R2: a watchdog without correct servicing keeps the secondary low.
  assert_wd_gate_R2: assert property (@(posedge clk) disable iff (!porN)
    !wdOk |=> !rst2N);

  // R3: peripheral supply low pulls both outputs.
  assert_peri_low_R3: assert property (@(posedge clk) disable iff (!porN)
    !periOk |=> (!rstN && !rst2N));

  // R7: incorrect watchdog trigger pulls both outputs.
  assert_wd_bad_R7: assert property (@(posedge clk) disable iff (!porN)
    wdBad |=> (!rstN && !rst2N));

  // R8: internal supply low pulls both outputs.
  assert_int_low_R8: assert property (@(posedge clk) disable iff (!porN)
    !intOk |=> (!rstN && !rst2N));

endmodule

// File: rtl/rst_merge.sv
`timescale 1ns/1ps
module rst_merge
  import rst_merge_pkg::*;
#(
  parameter int GLITCH_CYC = 4000,
  parameter int CORE_TICKS = 4
) (
  input  logic clk,
  input  logic porN,
  input  logic periOk,
  input  logic battOk,
  input  logic intOk,
  input  logic coreOver,
  input  logic coreUnder,
  input  logic regTick,
  input  logic regEn,
  input  logic regOvc,
  input  logic wdOk,
  input  logic wdBad,
  output logic rstN,
  output logic rst2N
);

  trip_t trips;

  rst_merge_ctrl #(
    .GLITCH_CYC (GLITCH_CYC),
    .CORE_TICKS (CORE_TICKS)
  ) i_ctrl (
    .clk       (clk),
    .porN      (porN),
    .battOk    (battOk),
    .coreOver  (coreOver),
    .coreUnder (coreUnder),
    .regTick   (regTick),
    .regEn     (regEn),
    .regOvc    (regOvc),
    .trips     (trips)
  );

  rst_merge_dp i_dp (
    .clk    (clk),
    .porN   (porN),
    .trips  (trips),
    .periOk (periOk),
    .intOk  (intOk),
    .wdBad  (wdBad),
    .wdOk   (wdOk),
    .rstN   (rstN),
    .rst2N  (rst2N)
  );

endmodule

// File: tb/test_rst_merge.sv
`timescale 1ns/1ps
module test_rst_merge;

  localparam int G = 10;
  localparam int C = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic porN, periOk, battOk, intOk, coreOver, coreUnder;
  logic regTick, regEn, regOvc, wdOk, wdBad;
  logic rstN, rst2N;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 0;

  rst_merge #(.GLITCH_CYC(G), .CORE_TICKS(C)) i_rst_merge (
    .clk(clk), .porN(porN), .periOk(periOk), .battOk(battOk), .intOk(intOk),
    .coreOver(coreOver), .coreUnder(coreUnder), .regTick(regTick),
    .regEn(regEn), .regOvc(regOvc), .wdOk(wdOk), .wdBad(wdBad),
    .rstN(rstN), .rst2N(rst2N)
  );

  // Behavioural reference: run lengths and a sticky flag, evaluated per edge.
  int   mBattLow;
  int   mCoreRun;
  bit   mOvc;
  logic expR, expR2;

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mBattLow = 0; mCoreRun = 0; mOvc = 0; expR = 0; expR2 = 0;
    end else begin
      bit ok;
      ok = periOk && intOk && !wdBad && !(!battOk && mBattLow >= G)
           && !(mCoreRun > C) && !mOvc;
      expR  = ok;
      expR2 = ok && wdOk;
      if (battOk) mBattLow = 0; else mBattLow = mBattLow + 1;
      if (regTick) mCoreRun = (coreOver || coreUnder) ? mCoreRun + 1 : 0;
      if (regEn && regOvc) mOvc = 1; else if (!regEn) mOvc = 0;
    end
  end

  // R9: every cycle out of reset the outputs match the model.
  always @(negedge clk) begin
    if (porN && !done) begin
      checks++;
      if (rstN !== expR || rst2N !== expR2) begin
        errors++;
        $display("FAIL R9 cycle compare at %0t: rstN=%b rst2N=%b expected %b %b",
                 $time, rstN, rst2N, expR, expR2);
      end
    end
  end

  task automatic chk(input string tag, input logic eR, input logic eR2);
    checks++;
    if (rstN !== eR || rst2N !== eR2) begin
      errors++;
      $display("FAIL %s: rstN=%b rst2N=%b expected %b %b", tag, rstN, rst2N, eR, eR2);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic ov, input logic un);
    coreOver = ov; coreUnder = un; regTick = 1'b1;
    step(1);
    regTick = 1'b0;
    step(2);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    porN = 0; periOk = 1; battOk = 1; intOk = 1; coreOver = 0; coreUnder = 0;
    regTick = 0; regEn = 0; regOvc = 0; wdOk = 1; wdBad = 0;
    step(3);
    chk("R1 held in power-on reset", 0, 0);
    porN = 1;
    step(1);
    chk("R9 first edge after reset", 1, 1);

    wdOk = 0; step(1); chk("R2 watchdog not ok", 1, 0);
    wdOk = 1; step(1); chk("R2 watchdog ok again", 1, 1);

    periOk = 0; step(1); chk("R3 peripheral low", 0, 0);
    periOk = 1; step(1); chk("R3 peripheral back", 1, 1);

    battOk = 0; step(3); battOk = 1; step(1); chk("R4 short dip ignored", 1, 1);
    battOk = 0; step(G); chk("R4 dip of window length ignored", 1, 1);
    step(1); chk("R4 dip past window trips", 0, 0);
    battOk = 1; step(1); chk("R4 release on first high", 1, 1);

    repeat (C) tick(1, 0);
    chk("R5 four faulty cycles tolerated", 1, 1);
    tick(0, 0);
    chk("R5 clean cycle keeps outputs high", 1, 1);
    repeat (C + 1) tick(0, 1);
    chk("R5 five faulty cycles trip", 0, 0);
    tick(0, 0);
    chk("R5 clean cycle releases", 1, 1);
    coreOver = 0; coreUnder = 0;

    regEn = 0; regOvc = 1; step(2); chk("R6 overcurrent ignored while disabled", 1, 1);
    regOvc = 0; regEn = 1; step(2); chk("R6 enabled without overcurrent", 1, 1);
    regOvc = 1; step(1); regOvc = 0; step(1); chk("R6 overcurrent latched", 0, 0);
    step(5); chk("R6 latch holds while enabled", 0, 0);
    regEn = 0; step(2); chk("R6 disable clears latch", 1, 1);

    wdBad = 1; step(1); chk("R7 wrong watchdog trigger", 0, 0);
    wdBad = 0; step(1); chk("R7 recovery", 1, 1);

    intOk = 0; step(1); chk("R8 internal supply low", 0, 0);
    intOk = 1; step(1); chk("R8 recovery", 1, 1);

    battOk = 0; step(G - 2);
    #1 porN = 0;
    #0.5 chk("R1 asynchronous assertion", 0, 0);
    step(2);
    porN = 1;
    step(3);
    chk("R1 filter cleared by reset", 1, 1);
    battOk = 1;
    step(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule